// File: doc/BRIEF.md
# Sequential Colour Table Loader

This block gives a host a narrow way to fill a 256-entry colour lookup table with 8-bit red, green and blue values. The host first writes a starting entry number to an index register, then streams colour components into a data register. An internal sequencer stores each incoming component into the red, green or blue table in turn for the current entry. After blue it moves on to the next entry by itself, so a whole palette can be loaded with one index write followed by a run of data writes.

The data register accepts either a single byte, carried on the top byte lane, or a full 32-bit word. A word carries four components, which are consumed most significant byte first. A small shift buffer feeds these bytes into the tables one per clock, and a ready output holds the host off until the buffer has drained. Every accepted data write also produces a one-cycle redraw request for the scanout side. A separate read port returns the three colour values of any entry one cycle after the entry number is presented.

Top module: `palette_loader`

## Requirements
- R1: An accepted write to offset 0 loads the current entry number from wr_data bits 7:0, ignores the upper bits, and makes red the next component to be stored.
- R2: Components delivered by data writes (offset 4) are stored into red, then green, then blue of the current entry, one component per clock, starting one clock after the write is accepted.
- R3: When a blue component is stored, the current entry number advances by one modulo 256 (255 wraps to 0) and red becomes the next component.
- R4: A data write with wr_word = 0 delivers exactly one component, taken from wr_data bits 31:24; bits 23:0 are ignored.
- R5: A data write with wr_word = 1 delivers four components in the order bits 31:24, 23:16, 15:8, 7:0, each advancing the sequencer as in R2 and R3.
- R6: After an accepted data write, wr_ready is low for 1 cycle (byte) or 4 cycles (word) and high otherwise; a write presented while wr_ready is low has no effect.
- R7: redraw_req is high for exactly the one cycle following each accepted data write and is low after index writes and ignored writes.
- R8: After a synchronous active-low reset, all 768 table bytes read as zero, the entry number is 0, red is the next component, wr_ready is high and redraw_req is low.
- R9: The read port returns, one cycle after rd_idx is presented, the stored red, green and blue values of that entry; when that entry is written on the same clock edge, the value before the write is returned.
- R10: An accepted write to any offset other than 0 and 4 changes no table entry, entry number or component position and raises no redraw request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write request |
| wr_off | input | 3 | Register offset of the write (0 = index, 4 = data) |
| wr_word | input | 1 | 1 = 32-bit write, 0 = single byte on bits 31:24 |
| wr_data | input | 32 | Write data |
| wr_ready | output | 1 | High when a write can be accepted |
| redraw_req | output | 1 | One-cycle full-redraw request after a data write |
| rd_idx | input | 8 | Entry number for the scanout read port |
| rd_red | output | 8 | Red value of the entry requested one cycle earlier |
| rd_grn | output | 8 | Green value of the entry requested one cycle earlier |
| rd_blu | output | 8 | Blue value of the entry requested one cycle earlier |

## Verification
The scanout read port and the drain of the shift buffer can touch the same table entry on the same clock edge. The bench provokes this by holding rd_idx on the entry that a byte write is about to fill, so the read and the store share one edge. The result is judged against R9: the sample taken after that edge must still show the old value, and the sample one cycle later the new one. A behavioural reference model, compared on every clock, covers the same overlap for every read during word drains.

// File: rtl/palette_pkg.sv
// Shared types for the colour table loader.
// Assumes three colour components, stored in the fixed order red, green, blue.
package palette_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } comp_phase_e;

    localparam int unsigned NUM_COMP = 3;

    // Next component after the given one, wrapping blue back to red.
    function automatic comp_phase_e next_phase(input comp_phase_e ph);
        case (ph)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/palette_seq.sv
// Write sequencer: decodes host writes, keeps the current entry number and
// component position, and drains data bytes one per clock from a shift buffer.
// Assumes that the host holds off while wr_ready is low; requests made then
// are dropped.
module palette_seq
    import palette_pkg::*;
#(
    parameter int unsigned IDX_W       = 8,
    parameter int unsigned COMP_W      = 8,
    parameter int unsigned BUS_W       = 32,
    parameter int unsigned OFF_W       = 3,
    parameter int unsigned IDX_OFFSET  = 0,
    parameter int unsigned DATA_OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic              wr_word,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              wr_ready,
    output logic              redraw_req,
    output logic [NUM_COMP-1:0] comp_we,
    output logic [IDX_W-1:0]  comp_idx,
    output logic [COMP_W-1:0] comp_val
);

    localparam int unsigned LANES = BUS_W / COMP_W;
    localparam int unsigned CNT_W = $clog2(LANES + 1);

    logic [IDX_W-1:0]  idx_q;
    comp_phase_e       phase_q;
    logic [BUS_W-1:0]  shbuf_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              redraw_q;

    logic accept, sel_idx, sel_data, drain;

    // Decode the request and whether the buffer is still draining.
    always_comb begin
        drain    = (cnt_q != '0);
        wr_ready = !drain;
        accept   = wr_en && wr_ready;
        sel_idx  = (wr_off == OFF_W'(IDX_OFFSET));
        sel_data = (wr_off == OFF_W'(DATA_OFFSET));
    end

    // Entry number, component position, shift buffer and redraw pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            phase_q  <= PH_RED;
            shbuf_q  <= '0;
            cnt_q    <= '0;
            redraw_q <= 1'b0;
        end else begin
            redraw_q <= accept && sel_data;
            if (drain) begin
                cnt_q   <= cnt_q - 1'b1;
                shbuf_q <= shbuf_q << COMP_W;
                phase_q <= next_phase(phase_q);
                if (phase_q == PH_BLU) begin
                    idx_q <= idx_q + 1'b1;
                end
            end else if (accept) begin
                if (sel_idx) begin
                    idx_q   <= wr_data[IDX_W-1:0];
                    phase_q <= PH_RED;
                end else if (sel_data) begin
                    shbuf_q <= wr_data;
                    cnt_q   <= wr_word ? CNT_W'(LANES) : CNT_W'(1);
                end
            end
        end
    end

    // Steer the top buffer byte to the table chosen by the component position.
    always_comb begin
        comp_we  = '0;
        comp_we[phase_q] = drain;
        comp_idx = idx_q;
        comp_val = shbuf_q[BUS_W-1 -: COMP_W];
    end

    assign redraw_req = redraw_q;

    // R1
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_idx) |=> (idx_q == $past(wr_data[IDX_W-1:0]) && phase_q == PH_RED));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && phase_q == PH_RED) |=> (phase_q == PH_GRN));

    // R3
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && phase_q == PH_BLU) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1) && phase_q == PH_RED));

    // R6
    busy_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && sel_data) |=> !wr_ready);

    // R7
    redraw_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redraw_q |-> $past(accept && sel_data));

endmodule

// File: rtl/palette_bank.sv
// One colour table: a register array with a single write port and a
// registered read port. A read of the entry written on the same edge
// returns the value held before that edge.
module palette_bank #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [COMP_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [COMP_W-1:0] rdata
);

    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [COMP_W-1:0] mem [ENTRIES];
    logic [COMP_W-1:0] rdata_q;

    // Clear on reset, otherwise store the write and register the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
            rdata_q <= '0;
        end else begin
            if (we) begin
                mem[waddr] <= wdata;
            end
            rdata_q <= mem[raddr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/palette_loader.sv
// Top level of the colour table loader: one write sequencer feeding three
// colour tables, each with its own read port for scanout.
// Assumes byte writes to the data register carry the component on the top lane.
module palette_loader
    import palette_pkg::*;
#(
    parameter int unsigned IDX_W       = 8,
    parameter int unsigned COMP_W      = 8,
    parameter int unsigned BUS_W       = 32,
    parameter int unsigned OFF_W       = 3,
    parameter int unsigned IDX_OFFSET  = 0,
    parameter int unsigned DATA_OFFSET = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic              wr_word,
    input  logic [BUS_W-1:0]  wr_data,
    output logic              wr_ready,
    output logic              redraw_req,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [COMP_W-1:0] rd_red,
    output logic [COMP_W-1:0] rd_grn,
    output logic [COMP_W-1:0] rd_blu
);

    logic [NUM_COMP-1:0] comp_we;
    logic [IDX_W-1:0]    comp_idx;
    logic [COMP_W-1:0]   comp_val;
    logic [COMP_W-1:0]   rd_comp [NUM_COMP];

    palette_seq #(
        .IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W), .OFF_W(OFF_W),
        .IDX_OFFSET(IDX_OFFSET), .DATA_OFFSET(DATA_OFFSET)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_off(wr_off), .wr_word(wr_word), .wr_data(wr_data),
        .wr_ready(wr_ready), .redraw_req(redraw_req),
        .comp_we(comp_we), .comp_idx(comp_idx), .comp_val(comp_val)
    );

    // One table per colour component, all sharing the write index and byte.
    for (genvar c = 0; c < NUM_COMP; c++) begin : g_bank
        palette_bank #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_bank (
            .clk(clk), .rst_n(rst_n),
            .we(comp_we[c]), .waddr(comp_idx), .wdata(comp_val),
            .raddr(rd_idx), .rdata(rd_comp[c])
        );
    end

    assign rd_red = rd_comp[PH_RED];
    assign rd_grn = rd_comp[PH_GRN];
    assign rd_blu = rd_comp[PH_BLU];

    // R2
    single_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(comp_we));

endmodule

// File: tb/sim_palette_loader.sv
module sim_palette_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_off = '0;
    logic        wr_word = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_idx = '0;
    logic        wr_ready, redraw_req;
    logic [7:0]  rd_red, rd_grn, rd_blu;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    palette_loader u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off),
        .wr_word(wr_word), .wr_data(wr_data), .wr_ready(wr_ready),
        .redraw_req(redraw_req), .rd_idx(rd_idx),
        .rd_red(rd_red), .rd_grn(rd_grn), .rd_blu(rd_blu)
    );

    // ---------------- behavioural reference model ----------------
    byte unsigned m_r [256];
    byte unsigned m_g [256];
    byte unsigned m_b [256];
    byte unsigned pend [$];
    int  m_idx = 0;
    int  m_ph  = 0;
    bit  e_redraw = 0;
    byte unsigned e_r = 0, e_g = 0, e_b = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                m_r[i] = 0; m_g[i] = 0; m_b[i] = 0;
            end
            pend.delete();
            m_idx = 0; m_ph = 0; e_redraw = 0;
            e_r = 0; e_g = 0; e_b = 0;
        end else begin
            bit acc;
            acc = wr_en && (pend.size() == 0);
            e_redraw = acc && (wr_off == 3'd4);
            e_r = m_r[rd_idx]; e_g = m_g[rd_idx]; e_b = m_b[rd_idx];
            if (pend.size() > 0) begin
                byte unsigned v;
                v = pend.pop_front();
                if (m_ph == 0) m_r[m_idx] = v;
                else if (m_ph == 1) m_g[m_idx] = v;
                else m_b[m_idx] = v;
                m_ph = m_ph + 1;
                if (m_ph == 3) begin
                    m_ph = 0;
                    m_idx = (m_idx + 1) % 256;
                end
            end else if (acc) begin
                if (wr_off == 3'd0) begin
                    m_idx = wr_data[7:0];
                    m_ph = 0;
                end else if (wr_off == 3'd4) begin
                    pend.push_back(wr_data[31:24]);
                    if (wr_word) begin
                        pend.push_back(wr_data[23:16]);
                        pend.push_back(wr_data[15:8]);
                        pend.push_back(wr_data[7:0]);
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R6 wr_ready vs model", wr_ready, (pend.size() == 0));
            chk("R7 redraw_req vs model", redraw_req, e_redraw);
            chk("R9 rd_red vs model", rd_red, e_r);
            chk("R9 rd_grn vs model", rd_grn, e_g);
            chk("R9 rd_blu vs model", rd_blu, e_b);
        end
    end

    // ---------------- stimulus helpers (start just after a negedge) ----------------
    task automatic wr(input logic [2:0] off, input logic word, input logic [31:0] d);
        while (!wr_ready) @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_word = word; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] idx,
                      input int er, input int eg, input int eb);
        while (!wr_ready) @(negedge clk);
        rd_idx = idx;
        @(negedge clk);
        chk({tag, " red"}, rd_red, er);
        chk({tag, " grn"}, rd_grn, eg);
        chk({tag, " blu"}, rd_blu, eb);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        do_reset();
        // R8 reset state
        chk("R8 ready after reset", wr_ready, 1);
        chk("R8 redraw after reset", redraw_req, 0);
        rd("R8 entry 0 cleared", 8'd0, 0, 0, 0);
        rd("R8 entry 255 cleared", 8'd255, 0, 0, 0);

        // R2 R4: byte writes fill red, green, blue of entry 5
        wr(3'd0, 1'b0, 32'h0000_0005);
        wr(3'd4, 1'b0, 32'h11AB_CDEF);
        chk("R7 redraw after data write", redraw_req, 1);
        wr(3'd4, 1'b0, 32'h2200_0000);
        wr(3'd4, 1'b0, 32'h3300_0000);
        rd("R2 R4 entry 5", 8'd5, 8'h11, 8'h22, 8'h33);
        // R3: next byte lands in red of entry 6
        wr(3'd4, 1'b0, 32'h4400_0000);
        rd("R3 entry 6 after advance", 8'd6, 8'h44, 0, 0);

        // R1: index write mid-entry, upper bits ignored, restarts at red
        wr(3'd0, 1'b0, 32'hFFFF_FF09);
        chk("R7 no redraw after index write", redraw_req, 0);
        wr(3'd4, 1'b0, 32'h5500_0000);
        rd("R1 entry 9 red", 8'd9, 8'h55, 0, 0);
        rd("R1 entry 6 untouched", 8'd6, 8'h44, 0, 0);

        // R5 R3: word writes across the 255 -> 0 wrap
        wr(3'd0, 1'b0, 32'h0000_00FE);
        wr(3'd4, 1'b1, 32'h0102_0304);
        wr(3'd4, 1'b1, 32'h0506_0708);
        rd("R5 entry 254", 8'd254, 8'h01, 8'h02, 8'h03);
        rd("R5 entry 255", 8'd255, 8'h04, 8'h05, 8'h06);
        rd("R3 wrap entry 0", 8'd0, 8'h07, 8'h08, 0);

        // R6: ready timing of a word write, with an ignored write while busy
        wr(3'd0, 1'b0, 32'h0000_0064);
        wr_en = 1'b1; wr_off = 3'd4; wr_word = 1'b1; wr_data = 32'h1020_3040;
        @(negedge clk);
        chk("R6 ready low 1 after word", wr_ready, 0);
        wr_off = 3'd0; wr_word = 1'b0; wr_data = 32'h0000_0077;
        @(negedge clk);
        chk("R6 ready low 2 after word", wr_ready, 0);
        @(negedge clk);
        chk("R6 ready low 3 after word", wr_ready, 0);
        @(negedge clk);
        chk("R6 ready low 4 after word", wr_ready, 0);
        wr_en = 1'b0;
        @(negedge clk);
        chk("R6 ready high after drain", wr_ready, 1);
        wr(3'd4, 1'b0, 32'h5000_0000);
        chk("R6 ready low after byte", wr_ready, 0);
        @(negedge clk);
        chk("R6 ready high after byte", wr_ready, 1);
        rd("R6 entry 101 continues", 8'd101, 8'h40, 8'h50, 0);
        rd("R6 busy index write ignored", 8'h77, 0, 0, 0);

        // R10: writes to other offsets have no effect
        wr(3'd2, 1'b1, 32'hDEAD_BEEF);
        chk("R10 no redraw for offset 2", redraw_req, 0);
        wr(3'd6, 1'b0, 32'hEE00_0000);
        wr(3'd4, 1'b0, 32'h6600_0000);
        rd("R10 entry 101 blue only from data", 8'd101, 8'h40, 8'h50, 8'h66);
        rd("R10 entry 102 untouched", 8'd102, 0, 0, 0);

        // R9: read and store of the same entry on one edge
        wr(3'd0, 1'b0, 32'h0000_001E);
        rd_idx = 8'd30;
        wr_en = 1'b1; wr_off = 3'd4; wr_word = 1'b0; wr_data = 32'h9900_0000;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R9 read before store", rd_red, 0);
        @(negedge clk);
        chk("R9 read on store edge returns old", rd_red, 0);
        @(negedge clk);
        chk("R9 read after store", rd_red, 8'h99);

        // R8: reset in the middle of a word drain clears everything
        wr_en = 1'b1; wr_off = 3'd4; wr_word = 1'b1; wr_data = 32'hAABB_CCDD;
        @(negedge clk);
        wr_en = 1'b0;
        do_reset();
        chk("R8 ready after second reset", wr_ready, 1);
        rd("R8 entry 5 cleared", 8'd5, 0, 0, 0);
        rd("R8 entry 30 cleared", 8'd30, 0, 0, 0);
        wr(3'd4, 1'b0, 32'h7700_0000);
        rd("R8 entry 0 red after reset", 8'd0, 8'h77, 0, 0);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule